// File: doc/BRIEF.md
# Teletext Request and Capture Controller

This block sits between an external teletext data source and a downstream text-line encoder. It tells the source when to send serial text bits, and it samples the returned bitstream on the pixel clock. It runs under a pixel clock enable, follows the line count and field flag from the video timing chain, and opens an insertion window on every line that software has selected for the current field.

Two request protocols are offered. In the per-bit protocol, each rising edge of the request output asks for one bit, and that bit is taken a programmable number of enabled clocks after the edge. In the window protocol, the request output rises once and stays high for the whole window. The text bit rate is not an integer fraction of the pixel rate, so the bit period comes from a phase accumulator whose increment is set by a configuration input. The window length, counted in bits including the clock run-in, depends on the selected text standard.

Every captured bit is presented with a one-cycle valid pulse. A done pulse marks the last bit of the window. Disabling the block, changing the standard while a window is open, or the start of a new line closes the window at once and drops any samples still pending.

Top module: `ttx_req_ctrl`

## Requirements
- R1: The standard code sets the bit count of a window: 2'b00 gives 360, 2'b01 gives 296, and 2'b10 or 2'b11 give 288. The window closes at the bit period that completes that count, and `win_done` pulses together with the `bit_valid` of the last captured bit.
- R2: In per-bit mode (`per_bit_mode`=1), `ttx_req` goes high for exactly one enabled clock per bit period, starting on the clock after the enabled edge at which the accumulator carries. It is low otherwise, so each bit has exactly one rising edge.
- R3: In window mode (`per_bit_mode`=0), `ttx_req` rises on the clock after the window opens, equals `win_active` after every enabled edge, and rises once per window.
- R4: The bit period comes from an ACC_W-bit accumulator. It is cleared when the window opens and adds `phase_inc` on each enabled edge while the window is open. Each carry out is one bit period. With ACC_W=8 and an increment of 128, a 360-bit window stays open for 720 enabled clocks.
- R5: `ttx_in` is sampled at the enabled edge that comes `req_dly`+1 enabled edges after the edge that raised the matching request pulse. The sampled value appears on `bit_data` with `bit_valid` high for one clock.
- R6: A pixel counter is cleared by the enabled edge at which `line_start` is high and counts enabled edges after that. The window opens at the enabled edge at which the count equals `start_ofs`. With the enable held high, `ttx_req` in window mode is first high in the clock `start_ofs`+2 cycles after the `line_start` cycle.
- R7: A window opens only when `line_num` lies in [LINE_FIRST, LINE_FIRST+NLINES) and mask bit `line_num`-LINE_FIRST is set in `lines_f0` (when `field`=0) or in `lines_f1` (when `field`=1).
- R8: If `start_ofs` plus the bit count of the selected standard exceeds LINE_PIX, the start position is ignored and no window opens on that line. A sum exactly equal to LINE_PIX still opens a window.
- R9: While `en` is low, no window opens. On the clock after `en` is seen low, `ttx_req`, `win_active` and `bit_valid` are low, and pending samples are dropped.
- R10: A change of `std_sel` while a window is open, or an enabled `line_start`, aborts the window in the same way as R9.
- R11: On clocks with `pix_ce` low, the pixel counter, the accumulator, the sample delay and the window state hold their values.
- R12: After reset, `ttx_req`, `win_active`, `bit_valid`, `bit_data` and `win_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| line_start | input | 1 | Marks the first pixel of a line (taken when pix_ce is high) |
| line_num | input | LINE_W | Current line number |
| field | input | 1 | 0 = first field, 1 = second field |
| en | input | 1 | Block enable |
| std_sel | input | 2 | Text standard code, sets the window bit count |
| per_bit_mode | input | 1 | 1 = per-bit request pulses, 0 = held window |
| req_dly | input | DLY_W | Sample delay in enabled clocks after a request edge |
| start_ofs | input | PIX_W | Window start as a pixel offset from the line start |
| phase_inc | input | ACC_W | Accumulator increment per enabled clock |
| lines_f0 | input | NLINES | Line enables for the first field |
| lines_f1 | input | NLINES | Line enables for the second field |
| ttx_in | input | 1 | Serial text bit from the source |
| ttx_req | output | 1 | Request to the source |
| bit_data | output | 1 | Captured bit |
| bit_valid | output | 1 | One-clock strobe for bit_data |
| win_active | output | 1 | Insertion window open |
| win_done | output | 1 | Last bit of the window captured |

## Verification
The bench builds the block with LINE_PIX=1024, NLINES=8, LINE_FIRST=4, an 8-bit accumulator and a 3-bit delay field. At these sizes a full 360-bit window fits in about 720 clocks, and a line of just over a thousand clocks reaches both the exact-fit and the overflow boundary of the start position. The small line range lets the bench place lines inside and outside the enabled range, and pick field masks that differ between the two fields. A pixel enable pattern of two clocks in three shows that the bit period and the sample delay count only enabled clocks.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

  localparam int CNT_W = 9;

  typedef enum logic [1:0] {
    STD_WST_625 = 2'b00,
    STD_WST_525 = 2'b01,
    STD_NA_TEXT = 2'b10,
    STD_SPARE   = 2'b11
  } ttx_std_e;

  // Bits per insertion window, run-in included.
  function automatic logic [CNT_W-1:0] win_bits(input logic [1:0] code);
    ttx_std_e s;
    s = ttx_std_e'(code);
    case (s)
      STD_WST_625: win_bits = CNT_W'(360);
      STD_WST_525: win_bits = CNT_W'(296);
      default:     win_bits = CNT_W'(288);
    endcase
  endfunction

endpackage

// File: rtl/ttx_line_gate.sv
module ttx_line_gate #(
  parameter int LINE_W     = 10,
  parameter int NLINES     = 24,
  parameter int LINE_FIRST = 6,
  parameter int LINE_PIX   = 1728,
  parameter int PIX_W      = 11,
  parameter int CNT_W      = 9
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  input  logic [NLINES-1:0] lines_f0,
  input  logic [NLINES-1:0] lines_f1,
  input  logic [PIX_W-1:0]  start_ofs,
  input  logic [CNT_W-1:0]  nbits,
  output logic              line_ok,
  output logic              fits
);
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int SUM_W = ((PIX_W > CNT_W) ? PIX_W : CNT_W) + 2;
  localparam logic [LINE_W:0] LO = (LINE_W+1)'(LINE_FIRST);
  localparam logic [LINE_W:0] HI = (LINE_W+1)'(LINE_FIRST + NLINES);

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [SUM_W-1:0] end_pos;

  always_comb begin
    in_range = ({1'b0, line_num} >= LO) && ({1'b0, line_num} < HI);
    idx      = IDX_W'(line_num - LINE_W'(LINE_FIRST));
    line_ok  = 1'b0;
    if (in_range) begin
      line_ok = field ? lines_f1[idx] : lines_f0[idx];
    end
    end_pos = SUM_W'(start_ofs) + SUM_W'(nbits);
    fits    = (end_pos <= SUM_W'(LINE_PIX));
  end

endmodule

// File: rtl/ttx_bit_clock.sv
module ttx_bit_clock #(
  parameter int ACC_W = 12,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             kill,
  input  logic             open,
  input  logic [ACC_W-1:0] phase_inc,
  input  logic [CNT_W-1:0] nbits,
  output logic             active,
  output logic             active_nxt,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, phase_inc};
    tick  = ce & act_q & ~kill & sum[ACC_W];
    act_d = act_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (kill) begin
      act_d = 1'b0;
    end else if (ce) begin
      if (act_q) begin
        acc_d = sum[ACC_W-1:0];
        if (sum[ACC_W]) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q + 1'b1 == nbits) act_d = 1'b0;
        end
      end else if (open) begin
        act_d = 1'b1;
        acc_d = '0;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign active     = act_q;
  assign active_nxt = act_d;

endmodule

// File: rtl/ttx_capture.sv
module ttx_capture #(
  parameter int DLY_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             kill,
  input  logic             open,
  input  logic             tick,
  input  logic [DLY_W-1:0] req_dly,
  input  logic             ttx_in,
  input  logic [CNT_W-1:0] nbits,
  output logic             bit_data,
  output logic             bit_valid,
  output logic             win_done
);
  localparam int DLY_MAX = (1 << DLY_W) - 1;

  logic [DLY_MAX:0] pipe_q, pipe_d;
  logic [CNT_W-1:0] smp_q, smp_d;
  logic             data_q, data_d;
  logic             vld_q, vld_d;
  logic             done_q, done_d;
  logic             hit, last;

  always_comb begin
    hit    = ce & ~kill & pipe_q[req_dly];
    last   = (smp_q + 1'b1 == nbits);
    pipe_d = pipe_q;
    if (kill) begin
      pipe_d = '0;
    end else if (ce) begin
      pipe_d = {pipe_q[DLY_MAX-1:0], tick};
    end
    vld_d  = hit;
    done_d = hit & last;
    data_d = hit ? ttx_in : data_q;
    smp_d  = smp_q;
    if (ce & ~kill & open) begin
      smp_d = '0;
    end else if (hit) begin
      smp_d = last ? '0 : smp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      smp_q  <= '0;
      data_q <= 1'b0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      smp_q  <= smp_d;
      data_q <= data_d;
      vld_q  <= vld_d;
      done_q <= done_d;
    end
  end

  assign bit_data  = data_q;
  assign bit_valid = vld_q;
  assign win_done  = done_q;

endmodule

// File: rtl/ttx_req_ctrl.sv
module ttx_req_ctrl #(
  parameter int LINE_PIX   = 1728,
  parameter int LINE_W     = 10,
  parameter int NLINES     = 24,
  parameter int LINE_FIRST = 6,
  parameter int ACC_W      = 12,
  parameter int DLY_W      = 4,
  localparam int PIX_W     = $clog2(LINE_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  input  logic              en,
  input  logic [1:0]        std_sel,
  input  logic              per_bit_mode,
  input  logic [DLY_W-1:0]  req_dly,
  input  logic [PIX_W-1:0]  start_ofs,
  input  logic [ACC_W-1:0]  phase_inc,
  input  logic [NLINES-1:0] lines_f0,
  input  logic [NLINES-1:0] lines_f1,
  input  logic              ttx_in,
  output logic              ttx_req,
  output logic              bit_data,
  output logic              bit_valid,
  output logic              win_active,
  output logic              win_done
);
  import ttx_pkg::*;

  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_PIX - 1);

  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic [1:0]       std_q, std_d;
  logic             req_q, req_d;
  logic             kill, open, line_ok, fits;
  logic             active, active_nxt, tick;
  logic [CNT_W-1:0] nbits_live, nbits_win;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign nbits_live = win_bits(std_sel);
  assign nbits_win  = win_bits(std_q);

  ttx_line_gate #(
    .LINE_W(LINE_W), .NLINES(NLINES), .LINE_FIRST(LINE_FIRST),
    .LINE_PIX(LINE_PIX), .PIX_W(PIX_W), .CNT_W(CNT_W)
  ) u_gate (
    .line_num(line_num), .field(field), .lines_f0(lines_f0),
    .lines_f1(lines_f1), .start_ofs(start_ofs), .nbits(nbits_live),
    .line_ok(line_ok), .fits(fits)
  );

  always_comb begin
    kill = ~en | (active & (std_sel != std_q)) | (pix_ce & line_start);
    open = pix_ce & ~kill & ~active & line_ok & fits & (pix_q == start_ofs);
  end

  ttx_bit_clock #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_clk (
    .clk(clk), .rst_n(rst_core_n), .ce(pix_ce), .kill(kill), .open(open),
    .phase_inc(phase_inc), .nbits(nbits_win),
    .active(active), .active_nxt(active_nxt), .tick(tick)
  );

  ttx_capture #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_core_n), .ce(pix_ce), .kill(kill), .open(open),
    .tick(tick), .req_dly(req_dly), .ttx_in(ttx_in), .nbits(nbits_win),
    .bit_data(bit_data), .bit_valid(bit_valid), .win_done(win_done)
  );

  always_comb begin
    pix_d = pix_q;
    if (pix_ce) begin
      if (line_start)            pix_d = '0;
      else if (pix_q != PIX_LAST) pix_d = pix_q + 1'b1;
    end
    std_d = open ? std_sel : std_q;
    req_d = req_q;
    if (kill)        req_d = 1'b0;
    else if (pix_ce) req_d = per_bit_mode ? tick : active_nxt;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pix_q <= '0;
      std_q <= 2'b00;
      req_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      std_q <= std_d;
      req_q <= req_d;
    end
  end

  assign ttx_req    = req_q;
  assign win_active = active;

endmodule

// File: rtl/ttx_req_checker.sv
module ttx_req_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_ce,
  input logic       en,
  input logic [1:0] std_sel,
  input logic       per_bit_mode,
  input logic       ttx_req,
  input logic       win_active,
  input logic       bit_valid,
  input logic       win_done
);

  p_done_with_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> bit_valid);

  p_req_edge_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ttx_req) |-> (win_active || $past(win_active)));

  p_req_tracks_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_bit_mode && pix_ce) |=> (ttx_req == win_active));

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ttx_req && !win_active && !bit_valid));

  p_open_on_enabled_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_active) |-> ($past(en) && $past(pix_ce)));

  p_hold_without_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && en && (std_sel == $past(std_sel))) |=> $stable(win_active));

endmodule

bind ttx_req_ctrl ttx_req_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .en(en), .std_sel(std_sel),
  .per_bit_mode(per_bit_mode), .ttx_req(ttx_req), .win_active(win_active),
  .bit_valid(bit_valid), .win_done(win_done)
);

// File: tb/tb_ttx_req_ctrl.sv
module tb_ttx_req_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LPIX   = 1024;
  localparam int LW     = 6;
  localparam int NL     = 8;
  localparam int LFIRST = 4;
  localparam int AW     = 8;
  localparam int DW     = 3;
  localparam int PW     = $clog2(LPIX);

  logic          clk, rst_n, pix_ce, line_start, field, en, per_bit_mode, ttx_in;
  logic [LW-1:0] line_num;
  logic [1:0]    std_sel;
  logic [DW-1:0] req_dly;
  logic [PW-1:0] start_ofs;
  logic [AW-1:0] phase_inc;
  logic [NL-1:0] lines_f0, lines_f1;
  logic          ttx_req, bit_data, bit_valid, win_active, win_done;

  int n_chk = 0;
  int n_fail = 0;

  ttx_req_ctrl #(.LINE_PIX(LPIX), .LINE_W(LW), .NLINES(NL), .LINE_FIRST(LFIRST),
                 .ACC_W(AW), .DLY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .line_start(line_start),
    .line_num(line_num), .field(field), .en(en), .std_sel(std_sel),
    .per_bit_mode(per_bit_mode), .req_dly(req_dly), .start_ofs(start_ofs),
    .phase_inc(phase_inc), .lines_f0(lines_f0), .lines_f1(lines_f1),
    .ttx_in(ttx_in), .ttx_req(ttx_req), .bit_data(bit_data),
    .bit_valid(bit_valid), .win_active(win_active), .win_done(win_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_bits(input int s);
    if (s == 0) return 360;
    if (s == 1) return 296;
    return 288;
  endfunction

  // behavioural reference model
  int m_pix, m_acc, m_ticks, m_std, m_smp;
  bit m_act, m_req, m_data, m_valid, m_done;
  int m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix = 0; m_acc = 0; m_ticks = 0; m_std = 0; m_smp = 0;
      m_act = 0; m_req = 0; m_data = 0; m_valid = 0; m_done = 0;
      m_q.delete();
    end else begin
      bit kill, ok_line, tick;
      int rel, s;
      kill = !en || (m_act && int'(std_sel) != m_std) || (pix_ce && line_start);
      m_valid = 0;
      m_done  = 0;
      if (kill) begin
        m_act = 0;
        m_req = 0;
        m_q.delete();
      end else if (pix_ce) begin
        if (m_q.size() > 0 && m_q[0] == 0) begin
          void'(m_q.pop_front());
          m_data  = ttx_in;
          m_valid = 1;
          m_smp++;
          if (m_smp == exp_bits(m_std)) begin
            m_done = 1;
            m_smp  = 0;
          end
        end
        foreach (m_q[i]) m_q[i]--;
        rel = int'(line_num) - LFIRST;
        ok_line = (rel >= 0) && (rel < NL) &&
                  (field ? lines_f1[rel] : lines_f0[rel]);
        if (m_act) begin
          s = m_acc + int'(phase_inc);
          tick = (s >= (1 << AW));
          m_acc = s % (1 << AW);
          if (tick) begin
            m_q.push_back(int'(req_dly));
            m_ticks++;
            if (m_ticks == exp_bits(m_std)) m_act = 0;
          end
          m_req = per_bit_mode ? tick : m_act;
        end else if (ok_line && m_pix == int'(start_ofs) &&
                     int'(start_ofs) + exp_bits(int'(std_sel)) <= LPIX) begin
          m_act = 1; m_acc = 0; m_ticks = 0; m_smp = 0;
          m_std = int'(std_sel);
          m_req = !per_bit_mode;
        end else begin
          m_req = 0;
        end
      end
      if (pix_ce) begin
        if (line_start)          m_pix = 0;
        else if (m_pix < LPIX-1) m_pix++;
      end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(ttx_req == m_req, "R2", "ttx_req vs model", ttx_req, m_req);
      chk(win_active == m_act, "R3", "win_active vs model", win_active, m_act);
      chk(bit_valid == m_valid, "R5", "bit_valid vs model", bit_valid, m_valid);
      if (m_valid) chk(bit_data == m_data, "R5", "bit_data vs model", bit_data, m_data);
      chk(win_done == m_done, "R1", "win_done vs model", win_done, m_done);
    end
  end

  int l_rises, l_first, l_high, l_after, l_valids, l_done;

  task automatic run_line(input int lnum, input bit fld, input int ncyc,
                          input int ce_mode, input int kill_at, input int kill_kind);
    bit prev;
    prev = ttx_req;
    l_rises = 0; l_first = -1; l_high = 0; l_after = 0; l_valids = 0; l_done = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (ttx_req && !prev) begin
        l_rises++;
        if (l_first < 0) l_first = i;
      end
      if (ttx_req) l_high++;
      if ((ttx_req || win_active) && kill_at >= 0 && i > kill_at) l_after++;
      if (bit_valid) l_valids++;
      if (win_done) l_done++;
      prev = ttx_req;
      line_start = (i == 0);
      line_num   = LW'(lnum);
      field      = fld;
      pix_ce     = (ce_mode == 0) ? 1'b1 : ((i % 3) != 2);
      ttx_in     = 1'($urandom_range(0, 1));
      if (i == kill_at) begin
        if (kill_kind == 1) en = 1'b0;
        else                std_sel = std_sel ^ 2'b01;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; pix_ce = 0; line_start = 0; line_num = '0; field = 0; en = 0;
    std_sel = 2'b00; per_bit_mode = 0; req_dly = '0; start_ofs = '0;
    phase_inc = '0; lines_f0 = '0; lines_f1 = '0; ttx_in = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk({ttx_req, win_active, bit_valid, bit_data, win_done} == 5'b0, "R12",
        "outputs in reset", {ttx_req, win_active, bit_valid, bit_data, win_done}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({ttx_req, win_active, bit_valid, win_done} == 4'b0, "R12",
        "outputs after reset", {ttx_req, win_active, bit_valid, win_done}, 0);
    cmp_on = 1;

    // 625-line teletext, held window
    en = 1; std_sel = 2'b00; per_bit_mode = 0; phase_inc = 8'd128; req_dly = 3'd2;
    start_ofs = 10; lines_f0 = 8'b0000_0010; lines_f1 = 8'b0;
    run_line(5, 0, 1100, 0, -1, 0);
    chk(l_rises == 1, "R3", "window rises", l_rises, 1);
    chk(l_high == 720, "R4", "window length in clocks", l_high, 720);
    chk(l_valids == 360, "R1", "bits captured 00", l_valids, 360);
    chk(l_done == 1, "R1", "done pulses", l_done, 1);
    chk(l_first == 12, "R6", "request start cycle", l_first, 12);

    // 525-line teletext, per-bit, second field only
    std_sel = 2'b01; per_bit_mode = 1; phase_inc = 8'd100; req_dly = 3'd3;
    start_ofs = 20; lines_f0 = 8'b0000_0000; lines_f1 = 8'b0000_0100;
    run_line(6, 1, 1100, 0, -1, 0);
    chk(l_rises == 296, "R2", "per-bit request edges", l_rises, 296);
    chk(l_valids == 296, "R5", "captured bits 01", l_valids, 296);
    chk(l_done == 1, "R1", "done pulses 01", l_done, 1);
    // same line in the first field is masked off
    run_line(6, 0, 1100, 0, -1, 0);
    chk(l_rises == 0, "R7", "masked field rises", l_rises, 0);
    chk(l_valids == 0, "R7", "masked field bits", l_valids, 0);
    // line outside the selectable range
    lines_f0 = 8'hFF;
    run_line(20, 0, 1100, 0, -1, 0);
    chk(l_rises == 0, "R7", "out-of-range line rises", l_rises, 0);

    // fit check on start offset
    std_sel = 2'b10; per_bit_mode = 0; phase_inc = 8'd128; req_dly = 3'd0;
    start_ofs = 800;
    run_line(5, 0, 1100, 0, -1, 0);
    chk(l_rises == 0, "R8", "overflowing start rises", l_rises, 0);
    start_ofs = 736;
    run_line(5, 0, 1400, 0, -1, 0);
    chk(l_rises == 1, "R8", "exact fit rises", l_rises, 1);
    chk(l_valids == 288, "R1", "bits captured 10", l_valids, 288);

    // disable in mid window
    std_sel = 2'b00; start_ofs = 10; req_dly = 3'd2;
    run_line(5, 0, 1100, 0, 200, 1);
    chk(l_after == 0, "R9", "activity after disable", l_after, 0);
    chk(l_valids < 360, "R9", "window cut short", l_valids, 359);
    run_line(5, 0, 1100, 0, -1, 0);
    chk(l_rises == 0, "R9", "rises while disabled", l_rises, 0);
    en = 1;

    // standard change in mid window
    run_line(5, 0, 1100, 0, 200, 2);
    chk(l_after == 0, "R10", "activity after standard change", l_after, 0);
    chk(l_done == 0, "R10", "done after abort", l_done, 0);

    // gated pixel enable, spare code, per-bit
    std_sel = 2'b11; per_bit_mode = 1; phase_inc = 8'd128; req_dly = 3'd1;
    run_line(7, 0, 1100, 1, -1, 0);
    chk(l_rises == 288, "R11", "edges under gated enable", l_rises, 288);
    chk(l_valids == 288, "R1", "bits captured 11", l_valids, 288);
    chk(l_done == 1, "R11", "done under gated enable", l_done, 1);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule